// File: doc/BRIEF.md
# PCI Inbound Memory Window Translator

This block maps CPU accesses that land in one of three fixed-size inbound memory windows onto 32-bit PCI memory addresses. Each window has a programmable base register, called BASEMAP here. Its contents supply the upper PCI address bits. Each window also has a companion SIDEMAP register, which software can read and write but which has no effect on translation. A 32-bit register port that accepts only full-word accesses reaches all six registers.

A translation request gives a window index and a byte offset inside that window. One clock later the block returns the PCI address, or raises an out-of-range flag. A variant strap chooses how BASEMAP is interpreted and which set of window sizes applies:

- In variant 0, the low nibble of BASEMAP becomes PCI address bits [31:28].
- In variant 1, BASEMAP is masked down to the window's power-of-two size.

The PCI I/O window is not translated by this block. It sits at PCI I/O address 0 and is 0x100000 bytes long in both variants.

Top module: `pcimw_xlate_top`

## Requirements
- R1: After a synchronous active-high reset, every BASEMAP and SIDEMAP register reads 0, and reg_rdata, reg_err, xl_rvalid, xl_addr and xl_oor are all 0.
- R2: The register map is:
  - BASEMAP window i sits at register offset 0x00 + 4*i.
  - SIDEMAP window i sits at register offset 0x10 + 4*i.
  - A full-word write (reg_be = 4'hF) stores reg_wdata.
  - A full-word read returns the stored value on reg_rdata in the cycle after the request, with reg_err low.
- R3: A request whose reg_be is anything other than 4'hF raises reg_err in the next cycle and changes no register.
- R4: A request to any offset outside the six listed above raises reg_err in the next cycle. This includes 0x0C, 0x1C, anything from 0x20 up, and any offset with non-zero low bits. Such a request changes no register and returns reg_rdata = 0.
- R5: With variant_sel = 0, the base of window i is BASEMAP[i][3:0] placed in bits [31:28], with all lower bits zero. BASEMAP bits [31:4] have no effect.
- R6: With variant_sel = 1, the base of window i is BASEMAP[i] with every bit below the window size cleared.
- R7: Window sizes are:
  - variant 0: 0x0C000000, 0x10000000 and 0x10000000 for windows 0, 1 and 2;
  - variant 1: 0x01000000, 0x04000000 and 0x08000000.
  
  An offset below the size gives xl_addr = base + offset with xl_oor = 0.
- R8: An offset equal to or above the selected window's size gives xl_oor = 1 and xl_addr = 0.
- R9: Window index 3 (no such window) gives xl_oor = 1 and xl_addr = 0.
- R10: xl_rvalid, xl_addr and xl_oor are registered. They carry the result of a request presented in the previous cycle and are all 0 when no request was presented. A BASEMAP write takes effect on a request presented in the cycle right after the write.
- R11: SIDEMAP contents never change a translation result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| variant_sel | input | 1 | Strap: 0 = nibble encoding, 1 = masked encoding |
| reg_req | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Register byte offset |
| reg_be | input | 4 | Byte enables, must be 4'hF |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after request |
| reg_err | output | 1 | Bad offset or partial access, one cycle after request |
| xl_valid | input | 1 | Translation request |
| xl_win | input | 2 | Window index |
| xl_off | input | 32 | Byte offset inside the window |
| xl_rvalid | output | 1 | Translation result valid |
| xl_addr | output | 32 | Translated PCI memory address |
| xl_oor | output | 1 | Offset or window index out of range |

## Verification
The assertions check these properties on every cycle:
- the one-cycle result pipeline and the zeroed idle outputs;
- a zero address whenever xl_oor is set, and xl_oor following a request with window index 3;
- reg_err and unchanged base registers after any partial-width access, and zero read data alongside an error;
- the variant-0 top nibble matching the base register that was current when the request was made.

Only the bench's scenarios can show the following:
- exact sums and masks for each variant and window;
- the size boundary at offsets size-1 and size;
- read-back after writes and after rejected writes to unmapped offsets;
- a base-register write being used by a request in the very next cycle;
- SIDEMAP contents leaving translations unchanged.

// File: rtl/pcimw_pkg.sv
package pcimw_pkg;
  localparam int DATA_W  = 32;
  localparam int NUM_WIN = 3;
  localparam int WIN_W   = 2;
  localparam int REG_AW  = 8;

  localparam logic [NUM_WIN*DATA_W-1:0] SIZES_NIB =
    {32'h1000_0000, 32'h1000_0000, 32'h0C00_0000};
  localparam logic [NUM_WIN*DATA_W-1:0] SIZES_MSK =
    {32'h0800_0000, 32'h0400_0000, 32'h0100_0000};

  typedef enum logic {VAR_NIBBLE = 1'b0, VAR_MASKED = 1'b1} variant_e;
endpackage

// File: rtl/pcimw_regfile.sv
module pcimw_regfile #(
  parameter int NUM_WIN = 3,
  parameter int DW      = 32,
  parameter int REG_AW  = 8,
  parameter logic [REG_AW-1:0] BASEMAP_OFS = 8'h00,
  parameter logic [REG_AW-1:0] SIDEMAP_OFS = 8'h10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req,
  input  logic                  we,
  input  logic [REG_AW-1:0]     addr,
  input  logic [DW/8-1:0]       be,
  input  logic [DW-1:0]         wdata,
  output logic [DW-1:0]         rdata,
  output logic                  err,
  output logic [NUM_WIN*DW-1:0] basemap_flat
);
  localparam int STRIDE = DW / 8;

  logic [DW-1:0]      basemap_q [NUM_WIN];
  logic [DW-1:0]      sidemap_q [NUM_WIN];
  logic [NUM_WIN-1:0] base_hit;
  logic [NUM_WIN-1:0] side_hit;
  logic               full_word;
  logic               mapped;
  logic               acc_ok;
  logic [DW-1:0]      rd_mux;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_dec
    assign base_hit[i] = (addr == REG_AW'(BASEMAP_OFS + STRIDE*i));
    assign side_hit[i] = (addr == REG_AW'(SIDEMAP_OFS + STRIDE*i));
    assign basemap_flat[i*DW +: DW] = basemap_q[i];
  end

  assign full_word = (be == {STRIDE{1'b1}});
  assign mapped    = (|base_hit) | (|side_hit);
  assign acc_ok    = req & full_word & mapped;

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (base_hit[i]) rd_mux = rd_mux | basemap_q[i];
      if (side_hit[i]) rd_mux = rd_mux | sidemap_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err   <= 1'b0;
      rdata <= '0;
      for (int i = 0; i < NUM_WIN; i++) begin
        basemap_q[i] <= '0;
        sidemap_q[i] <= '0;
      end
    end else begin
      err   <= req & ~(full_word & mapped);
      rdata <= (acc_ok & ~we) ? rd_mux : '0;
      for (int i = 0; i < NUM_WIN; i++) begin
        if (acc_ok & we & base_hit[i]) basemap_q[i] <= wdata;
        if (acc_ok & we & side_hit[i]) sidemap_q[i] <= wdata;
      end
    end
  end
endmodule

// File: rtl/pcimw_win_base.sv
module pcimw_win_base #(
  parameter int DW = 32,
  parameter logic [DW-1:0] SIZE_NIB = 32'h1000_0000,
  parameter logic [DW-1:0] SIZE_MSK = 32'h0100_0000
) (
  input  logic          variant,
  input  logic [DW-1:0] basemap,
  output logic [DW-1:0] base,
  output logic [DW-1:0] size
);
  localparam int          NIB_SHIFT = DW - 4;
  localparam logic [DW-1:0] KEEP_MSK = ~(SIZE_MSK - 1);

  always_comb begin
    if (variant == pcimw_pkg::VAR_MASKED) begin
      base = basemap & KEEP_MSK;
      size = SIZE_MSK;
    end else begin
      base = basemap << NIB_SHIFT;
      size = SIZE_NIB;
    end
  end
endmodule

// File: rtl/pcimw_xlate_stage.sv
module pcimw_xlate_stage #(
  parameter int NUM_WIN = 3,
  parameter int WIN_W   = 2,
  parameter int DW      = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  valid,
  input  logic [WIN_W-1:0]      win,
  input  logic [DW-1:0]         off,
  input  logic [NUM_WIN*DW-1:0] base_flat,
  input  logic [NUM_WIN*DW-1:0] size_flat,
  output logic                  rvalid,
  output logic [DW-1:0]         addr,
  output logic                  oor
);
  logic [DW-1:0] sel_base;
  logic [DW-1:0] sel_size;
  logic          win_ok;
  logic          in_rng;
  logic [DW-1:0] nxt_addr;

  always_comb begin
    sel_base = '0;
    sel_size = '0;
    win_ok   = 1'b0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (win == WIN_W'(i)) begin
        sel_base = base_flat[i*DW +: DW];
        sel_size = size_flat[i*DW +: DW];
        win_ok   = 1'b1;
      end
    end
    in_rng   = win_ok && (off < sel_size);
    nxt_addr = in_rng ? (sel_base + off) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      addr   <= '0;
      oor    <= 1'b0;
    end else begin
      rvalid <= valid;
      addr   <= valid ? nxt_addr : '0;
      oor    <= valid & ~in_rng;
    end
  end
endmodule

// File: rtl/pcimw_xlate_top.sv
module pcimw_xlate_top #(
  parameter int NUM_WIN = pcimw_pkg::NUM_WIN,
  parameter int DW      = pcimw_pkg::DATA_W,
  parameter int WIN_W   = pcimw_pkg::WIN_W,
  parameter int REG_AW  = pcimw_pkg::REG_AW,
  parameter logic [NUM_WIN*DW-1:0] SIZES_NIB = pcimw_pkg::SIZES_NIB,
  parameter logic [NUM_WIN*DW-1:0] SIZES_MSK = pcimw_pkg::SIZES_MSK
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              variant_sel,
  input  logic              reg_req,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW/8-1:0]   reg_be,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              reg_err,
  input  logic              xl_valid,
  input  logic [WIN_W-1:0]  xl_win,
  input  logic [DW-1:0]     xl_off,
  output logic              xl_rvalid,
  output logic [DW-1:0]     xl_addr,
  output logic              xl_oor
);
  logic [NUM_WIN*DW-1:0] basemap_flat;
  logic [NUM_WIN*DW-1:0] base_flat;
  logic [NUM_WIN*DW-1:0] size_flat;

  pcimw_regfile #(
    .NUM_WIN(NUM_WIN), .DW(DW), .REG_AW(REG_AW)
  ) regs_i (
    .clk(clk), .rst(rst), .req(reg_req), .we(reg_we), .addr(reg_addr),
    .be(reg_be), .wdata(reg_wdata), .rdata(reg_rdata), .err(reg_err),
    .basemap_flat(basemap_flat)
  );

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    pcimw_win_base #(
      .DW(DW),
      .SIZE_NIB(SIZES_NIB[i*DW +: DW]),
      .SIZE_MSK(SIZES_MSK[i*DW +: DW])
    ) wb_i (
      .variant(variant_sel),
      .basemap(basemap_flat[i*DW +: DW]),
      .base(base_flat[i*DW +: DW]),
      .size(size_flat[i*DW +: DW])
    );
  end

  pcimw_xlate_stage #(
    .NUM_WIN(NUM_WIN), .WIN_W(WIN_W), .DW(DW)
  ) xl_i (
    .clk(clk), .rst(rst), .valid(xl_valid), .win(xl_win), .off(xl_off),
    .base_flat(base_flat), .size_flat(size_flat),
    .rvalid(xl_rvalid), .addr(xl_addr), .oor(xl_oor)
  );
endmodule

// File: rtl/pcimw_chk.sv
module pcimw_chk #(
  parameter int NUM_WIN = 3,
  parameter int DW      = 32,
  parameter int WIN_W   = 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  variant_sel,
  input logic                  reg_req,
  input logic [DW/8-1:0]       reg_be,
  input logic                  reg_err,
  input logic [DW-1:0]         reg_rdata,
  input logic                  xl_valid,
  input logic [WIN_W-1:0]      xl_win,
  input logic                  xl_rvalid,
  input logic [DW-1:0]         xl_addr,
  input logic                  xl_oor,
  input logic [NUM_WIN*DW-1:0] basemap_flat
);
  logic [3:0] sel_nib;
  logic       win_bad;

  always_comb begin
    sel_nib = '0;
    for (int i = 0; i < NUM_WIN; i++)
      if (xl_win == WIN_W'(i)) sel_nib = basemap_flat[i*DW +: 4];
  end
  assign win_bad = (int'(xl_win) >= NUM_WIN);

  AST_RVALID_PIPE: assert property (@(posedge clk) disable iff (rst)
    xl_valid |=> xl_rvalid); // R10
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !xl_rvalid |-> (xl_addr == '0 && !xl_oor)); // R10
  AST_OOR_ADDR_ZERO: assert property (@(posedge clk) disable iff (rst)
    xl_oor |-> xl_addr == '0); // R8
  AST_BAD_WIN_OOR: assert property (@(posedge clk) disable iff (rst)
    (xl_valid && win_bad) |=> xl_oor); // R9
  AST_PARTIAL_ERR: assert property (@(posedge clk) disable iff (rst)
    (reg_req && reg_be != '1) |=> reg_err); // R3
  AST_PARTIAL_NOWRITE: assert property (@(posedge clk) disable iff (rst)
    (reg_req && reg_be != '1) |=> $stable(basemap_flat)); // R3
  AST_ERR_RDATA_ZERO: assert property (@(posedge clk) disable iff (rst)
    reg_err |-> reg_rdata == '0); // R4
  AST_NIB_TOP: assert property (@(posedge clk) disable iff (rst)
    (xl_valid && !variant_sel && !win_bad) |=>
      (xl_oor || xl_addr[DW-1 -: 4] == $past(sel_nib))); // R5
endmodule

bind pcimw_xlate_top pcimw_chk #(
  .NUM_WIN(NUM_WIN), .DW(DW), .WIN_W(WIN_W)
) chk_i (
  .clk(clk), .rst(rst), .variant_sel(variant_sel), .reg_req(reg_req),
  .reg_be(reg_be), .reg_err(reg_err), .reg_rdata(reg_rdata),
  .xl_valid(xl_valid), .xl_win(xl_win), .xl_rvalid(xl_rvalid),
  .xl_addr(xl_addr), .xl_oor(xl_oor), .basemap_flat(basemap_flat)
);

// File: tb/pcimw_xlate_top_tb_top.sv
module pcimw_xlate_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        variant_sel;
  logic        reg_req, reg_we;
  logic [7:0]  reg_addr;
  logic [3:0]  reg_be;
  logic [31:0] reg_wdata, reg_rdata;
  logic        reg_err;
  logic        xl_valid;
  logic [1:0]  xl_win;
  logic [31:0] xl_off, xl_addr;
  logic        xl_rvalid, xl_oor;

  int checks = 0;
  int fails  = 0;
  logic [31:0] m_base [3];
  logic [31:0] m_side [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  pcimw_xlate_top dut_i (
    .clk(clk), .rst(rst), .variant_sel(variant_sel),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_err(reg_err),
    .xl_valid(xl_valid), .xl_win(xl_win), .xl_off(xl_off),
    .xl_rvalid(xl_rvalid), .xl_addr(xl_addr), .xl_oor(xl_oor)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_size(input bit v, input int w);
    case ({v, 2'(w)})
      3'b000:  return 32'h0C00_0000;
      3'b001:  return 32'h1000_0000;
      3'b010:  return 32'h1000_0000;
      3'b100:  return 32'h0100_0000;
      3'b101:  return 32'h0400_0000;
      3'b110:  return 32'h0800_0000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [32:0] exp_xl(input bit v, input int w,
                                         input logic [31:0] off);
    logic [31:0] sz, b;
    if (w > 2) return {1'b1, 32'h0};
    sz = exp_size(v, w);
    if (off >= sz) return {1'b1, 32'h0};
    b = v ? (m_base[w] & ~(sz - 32'd1)) : {m_base[w][3:0], 28'h0};
    return {1'b0, b + off};
  endfunction

  task automatic reg_acc(input bit we, input logic [7:0] a, input logic [3:0] be,
                         input logic [31:0] d, output logic [31:0] rd,
                         output logic er);
    @(negedge clk);
    reg_req = 1'b1; reg_we = we; reg_addr = a; reg_be = be; reg_wdata = d;
    @(negedge clk);
    reg_req = 1'b0; reg_we = 1'b0;
    rd = reg_rdata; er = reg_err;
  endtask

  task automatic good_write(input logic [7:0] a, input logic [31:0] d,
                            input string tag);
    logic [31:0] rd; logic er;
    reg_acc(1'b1, a, 4'hF, d, rd, er);
    chk(er == 1'b0, tag, {31'h0, er}, 32'h0);
    if (a[4]) m_side[a[3:2]] = d; else m_base[a[3:2]] = d;
  endtask

  task automatic read_exp(input logic [7:0] a, input logic [31:0] exp,
                          input bit exp_err, input string tag);
    logic [31:0] rd; logic er;
    reg_acc(1'b0, a, 4'hF, 32'h0, rd, er);
    chk(rd == exp && er == exp_err, tag, rd, exp);
  endtask

  task automatic check_all_regs(input string tag);
    for (int i = 0; i < 3; i++) begin
      read_exp(8'(4*i), m_base[i], 1'b0, tag);
      read_exp(8'(8'h10 + 4*i), m_side[i], 1'b0, tag);
    end
  endtask

  task automatic xlate(input int w, input logic [31:0] off, input string tag);
    logic [32:0] e;
    @(negedge clk);
    xl_valid = 1'b1; xl_win = 2'(w); xl_off = off;
    e = exp_xl(variant_sel, w, off);
    @(negedge clk);
    xl_valid = 1'b0;
    chk(xl_rvalid == 1'b1 && xl_oor == e[32] && xl_addr == e[31:0],
        tag, xl_addr, e[31:0]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd; logic er;
    void'($urandom(32'd2718));
    rst = 1'b1; variant_sel = 1'b0;
    reg_req = 0; reg_we = 0; reg_addr = 0; reg_be = 0; reg_wdata = 0;
    xl_valid = 0; xl_win = 0; xl_off = 0;
    for (int i = 0; i < 3; i++) begin m_base[i] = 0; m_side[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk(xl_rvalid == 0 && xl_addr == 0 && xl_oor == 0 && reg_err == 0 &&
        reg_rdata == 0, "R1 outputs", xl_addr, 32'h0);
    check_all_regs("R1 regs");

    // R2: write/read all registers
    good_write(8'h00, 32'hFFFF_FFF5, "R2 wr");
    good_write(8'h04, 32'h1234_567A, "R2 wr");
    good_write(8'h08, 32'hA5A5_0003, "R2 wr");
    good_write(8'h10, 32'hDEAD_BEEF, "R2 wr");
    good_write(8'h14, 32'h0000_0001, "R2 wr");
    good_write(8'h18, 32'h8000_0000, "R2 wr");
    check_all_regs("R2 readback");

    // R3: partial byte enables rejected
    reg_acc(1'b1, 8'h04, 4'h3, 32'h0, rd, er);
    chk(er == 1'b1, "R3 err", {31'h0, er}, 32'h1);
    reg_acc(1'b1, 8'h14, 4'h8, 32'hFFFF_FFFF, rd, er);
    chk(er == 1'b1, "R3 err", {31'h0, er}, 32'h1);
    check_all_regs("R3 unchanged");

    // R4: unmapped offsets
    reg_acc(1'b1, 8'h0C, 4'hF, 32'h7777_7777, rd, er);
    chk(er == 1'b1, "R4 err 0C", {31'h0, er}, 32'h1);
    reg_acc(1'b1, 8'h1C, 4'hF, 32'h7777_7777, rd, er);
    chk(er == 1'b1, "R4 err 1C", {31'h0, er}, 32'h1);
    reg_acc(1'b1, 8'h02, 4'hF, 32'h7777_7777, rd, er);
    chk(er == 1'b1, "R4 err 02", {31'h0, er}, 32'h1);
    read_exp(8'h20, 32'h0, 1'b1, "R4 rd 20");
    read_exp(8'h0C, 32'h0, 1'b1, "R4 rd 0C");
    check_all_regs("R4 unchanged");

    // R5, R7, R8: nibble variant
    variant_sel = 1'b0;
    xlate(0, 32'h0, "R5 w0 off0");
    xlate(0, 32'h0BFF_FFFF, "R7 w0 last");
    xlate(0, 32'h0C00_0000, "R8 w0 edge");
    xlate(1, 32'h0FFF_FFFF, "R7 w1 last");
    xlate(2, 32'h0012_3456, "R5 w2 upper ignored");
    xlate(1, 32'hFFFF_FFFF, "R8 w1 far");

    // R6, R7, R8: masked variant
    variant_sel = 1'b1;
    xlate(0, 32'h00FF_FFFF, "R6 w0 last");
    xlate(0, 32'h0100_0000, "R8 w0 edge v1");
    xlate(1, 32'h0000_0010, "R6 w1");
    xlate(2, 32'h07FF_FFFC, "R7 w2 last v1");
    xlate(2, 32'h0800_0000, "R8 w2 edge v1");

    // R9: no such window
    xlate(3, 32'h0, "R9 win3");
    variant_sel = 1'b0;
    xlate(3, 32'h10, "R9 win3 v0");

    // R10: write then translate in the very next cycle
    @(negedge clk);
    reg_req = 1; reg_we = 1; reg_addr = 8'h08; reg_be = 4'hF;
    reg_wdata = 32'h0000_000C;
    m_base[2] = 32'h0000_000C;
    @(negedge clk);
    reg_req = 0; reg_we = 0;
    xl_valid = 1; xl_win = 2'd2; xl_off = 32'h0000_0400;
    @(negedge clk);
    xl_valid = 0;
    chk(xl_rvalid && !xl_oor && xl_addr == 32'hC000_0400, "R10 next-cycle",
        xl_addr, 32'hC000_0400);
    @(negedge clk);
    chk(!xl_rvalid && xl_addr == 0 && !xl_oor, "R10 idle", xl_addr, 32'h0);

    // R11: SIDEMAP has no effect
    xlate(2, 32'h0000_1234, "R11 before");
    good_write(8'h18, 32'hFFFF_FFFF, "R11 wr");
    xlate(2, 32'h0000_1234, "R11 after");
    variant_sel = 1'b1;
    good_write(8'h10, 32'h0F0F_0F0F, "R11 wr");
    xlate(0, 32'h0000_1234, "R11 after v1");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int kind;
      int w;
      logic [31:0] off;
      kind = int'($urandom % 5);
      w    = int'($urandom % 4);
      if (kind == 0) begin
        if (w < 3) good_write(8'(4*w), $urandom, "R2 rnd wr");
      end else if (kind == 1) begin
        variant_sel = $urandom % 2;
      end else begin
        if (w < 3 && ($urandom % 4) != 0)
          off = $urandom % exp_size(variant_sel, w);
        else
          off = $urandom;
        xlate(w, off, variant_sel ? "R6 R7 rnd" : "R5 R7 rnd");
      end
    end
    check_all_regs("R2 rnd final");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule